// File: doc/BRIEF.md
# FEAC Code Word Transmitter

This block drives the far-end alarm and control (FEAC) bit of a DS3 framer that runs in C-bit parity mode. It emits one bit per strobe from the framer, one strobe for each FEAC slot. It repeats a fixed 16-slot code word made of eight flag ones followed by the eight bits of a message byte. The message is sent least significant bit first.

A message byte is sent only when its top and bottom bits are both zero and the framer is in C-bit parity mode. Otherwise the channel sends ones in every slot. The block takes a snapshot of the byte at each word boundary, so a byte changed partway through a word is not sent until the following word.

An optional interrupt pulse marks the end of every code word. It also marks every switch between sending a message and idling.

Top module: `feac_tx`

## Requirements
- R1: After synchronous reset, `feac_bit` is 1 and `irq` is 0, and the first code word is all ones.
- R2: A code word lasts 16 strobes. Word slot 0 is the first strobe after reset or after the previous word ends. Slots 0 to 7 carry 1. Slots 8 to 15 carry message bits 0 to 7 in that order. `feac_bit` takes the new value on the clock edge that samples the strobe and holds it between strobes.
- R3: A byte with bit 7 = 0 and bit 0 = 0 is a valid message. While it stays valid and `cbit_mode` = 1, it is sent after every flag, word after word.
- R4: A byte with bit 7 = 1 or bit 0 = 1 makes every slot of the word 1.
- R5: With `cbit_mode` = 0 every slot is 1, whatever the byte.
- R6: The byte and the mode are sampled on the strobe that ends a word and govern the whole next word. A change made during a word never alters the word in progress.
- R7: With `irq_en` = 1, `irq` is 1 for the cycle that follows the strobe ending each word.
- R8: With `irq_en` = 1, `irq` pulses one cycle after the message/idle status changes. The status is message when `cbit_mode` = 1 and the byte is valid, and idle otherwise. A change of byte or of mode triggers the pulse with no strobe needed.
- R9: With `irq_en` = 0, `irq` stays 0.
- R10: When a word end and a status change fall on the same edge, `irq` is a single one-cycle pulse. The new status also governs the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | One-cycle strobe for each FEAC bit slot |
| cbit_mode | input | 1 | 1 = C-bit parity mode |
| msg_byte | input | MSG_W | Message byte register |
| irq_en | input | 1 | Interrupt enable |
| feac_bit | output | 1 | Serial FEAC bit (registered) |
| irq | output | 1 | Interrupt pulse (registered) |

## Verification
The word-end interrupt and the status-change interrupt can fall in the same cycle. The word snapshot can also coincide with a byte write. The bench provokes both cases together: on the last strobe of a word that carries a valid byte, it writes an invalid byte in the same cycle as the strobe. It then requires three results. The slot-15 bit still belongs to the old byte. `irq` is high for exactly one cycle. The next whole word is all ones.

// File: rtl/feac_pkg.sv
package feac_pkg;
  typedef enum logic {
    LINK_IDLE = 1'b0,
    LINK_MSG  = 1'b1
  } link_e;
endpackage

// File: rtl/feac_word_builder.sv
module feac_word_builder #(
  parameter int MSG_W  = 8,
  parameter int FLAG_W = 8,
  localparam int WORD_W = MSG_W + FLAG_W
) (
  input  logic [MSG_W-1:0]  msg,
  input  logic              cbit_mode,
  output logic [WORD_W-1:0] word,
  output feac_pkg::link_e   link
);
  // A message is sendable only in C-bit mode with both end bits clear.
  always_comb begin
    if (cbit_mode && !msg[MSG_W-1] && !msg[0]) link = feac_pkg::LINK_MSG;
    else                                       link = feac_pkg::LINK_IDLE;
  end

  // Word, LSB leaves first: flag ones in the low bits, message above.
  always_comb begin
    if (link == feac_pkg::LINK_MSG) word = {msg, {FLAG_W{1'b1}}};
    else                            word = '1;
  end
endmodule

// File: rtl/feac_serializer.sv
module feac_serializer #(
  parameter int WORD_W = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_stb,
  input  logic [WORD_W-1:0] load_word,
  output logic              tx_bit,
  output logic              word_end
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FLAG_END = CNT_W'(FLAG_W);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;

  assign word_end = slot_stb && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sh     <= '1;
      tx_bit <= 1'b1;
    end else if (slot_stb) begin
      tx_bit <= sh[0];
      if (word_end) begin
        cnt <= '0;
        sh  <= load_word;
      end else begin
        cnt <= cnt + 1'b1;
        sh  <= {1'b1, sh[WORD_W-1:1]};
      end
    end
  end

  // R2: output moves only on a slot strobe
  a_r2_hold_between_slots: assert property (@(posedge clk) disable iff (rst)
    !slot_stb |=> $stable(tx_bit));
  // R2: counter restarts after the last slot
  a_r2_word_wrap: assert property (@(posedge clk) disable iff (rst)
    word_end |=> (cnt == '0));
  // R2: flag slots always carry ones
  a_r2_flag_ones: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && (cnt < FLAG_END)) |=> tx_bit);
endmodule

// File: rtl/feac_irq_gen.sv
module feac_irq_gen (
  input  logic            clk,
  input  logic            rst,
  input  logic            word_end,
  input  feac_pkg::link_e link,
  input  logic            irq_en,
  output logic            irq
);
  feac_pkg::link_e link_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_prev <= feac_pkg::LINK_IDLE;
      irq       <= 1'b0;
    end else begin
      link_prev <= link;
      irq       <= irq_en && (word_end || (link != link_prev));
    end
  end

  // R9: no pulse without the enable
  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));
  // R7: every word end raises the pulse when enabled
  a_r7_word_end_pulse: assert property (@(posedge clk) disable iff (rst)
    (word_end && irq_en) |=> irq);
endmodule

// File: rtl/feac_tx.sv
module feac_tx #(
  parameter int MSG_W  = 8,
  parameter int FLAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_stb,
  input  logic             cbit_mode,
  input  logic [MSG_W-1:0] msg_byte,
  input  logic             irq_en,
  output logic             feac_bit,
  output logic             irq
);
  localparam int WORD_W = MSG_W + FLAG_W;

  logic [WORD_W-1:0] next_word;
  feac_pkg::link_e   link;
  logic              word_end;

  feac_word_builder #(.MSG_W(MSG_W), .FLAG_W(FLAG_W)) u_build (
    .msg(msg_byte), .cbit_mode(cbit_mode), .word(next_word), .link(link)
  );

  feac_serializer #(.WORD_W(WORD_W), .FLAG_W(FLAG_W)) u_ser (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .load_word(next_word),
    .tx_bit(feac_bit), .word_end(word_end)
  );

  feac_irq_gen u_irq (
    .clk(clk), .rst(rst), .word_end(word_end), .link(link),
    .irq_en(irq_en), .irq(irq)
  );

  // R1: reset leaves the line idle and quiet
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (feac_bit && !irq));
endmodule

// File: tb/sim_feac_tx.sv
module sim_feac_tx;
  logic clk = 1'b0;
  logic rst, stb, mode, en;
  logic [7:0] msg;
  logic fb, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  feac_tx u0 (.clk(clk), .rst(rst), .slot_stb(stb), .cbit_mode(mode),
              .msg_byte(msg), .irq_en(en), .feac_bit(fb), .irq(irq));

  function automatic logic [15:0] exp_word(input logic [7:0] m, input logic md);
    return (md && !m[7] && !m[0]) ? {m, 8'hFF} : 16'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_slot(output logic b, output logic q);
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
    b = fb; q = irq;
  endtask

  task automatic run_word(output logic [15:0] w, output logic [15:0] iq);
    for (int i = 0; i < 16; i++) step_slot(w[i], iq[i]);
  endtask

  task automatic t_reset();
    logic [15:0] w, iq;
    rst = 1'b1; stb = 1'b0; mode = 1'b1; en = 1'b0; msg = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fb == 1'b1, "R1 reset feac_bit", fb, 1);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    run_word(w, iq);
    chk(w == 16'hFFFF, "R1 first word idle", w, 16'hFFFF);
  endtask

  task automatic t_valid();
    logic [15:0] w, iq;
    msg = 8'h36;
    run_word(w, iq);
    run_word(w, iq);
    chk(w == exp_word(8'h36, 1'b1), "R2 flag then LSB-first byte 36", w, exp_word(8'h36, 1'b1));
    run_word(w, iq);
    chk(w == exp_word(8'h36, 1'b1), "R3 byte 36 repeats", w, exp_word(8'h36, 1'b1));
    msg = 8'h02;
    run_word(w, iq);
    run_word(w, iq);
    chk(w == exp_word(8'h02, 1'b1), "R3 byte 02", w, exp_word(8'h02, 1'b1));
  endtask

  task automatic t_invalid();
    logic [15:0] w, iq;
    msg = 8'h37;
    run_word(w, iq);
    run_word(w, iq);
    chk(w == 16'hFFFF, "R4 bit0 set idles", w, 16'hFFFF);
    msg = 8'hB6;
    run_word(w, iq);
    run_word(w, iq);
    chk(w == 16'hFFFF, "R4 bit7 set idles", w, 16'hFFFF);
  endtask

  task automatic t_mode();
    logic [15:0] w, iq;
    msg = 8'h36; mode = 1'b0;
    run_word(w, iq);
    run_word(w, iq);
    chk(w == 16'hFFFF, "R5 other mode idles", w, 16'hFFFF);
    mode = 1'b1;
    run_word(w, iq);
  endtask

  task automatic t_midword();
    logic [15:0] w, iq;
    msg = 8'h36;
    run_word(w, iq);
    for (int i = 0; i < 8; i++) step_slot(w[i], iq[i]);
    msg = 8'h4C;
    for (int i = 8; i < 16; i++) step_slot(w[i], iq[i]);
    chk(w == exp_word(8'h36, 1'b1), "R6 mid-word write not in current word", w, exp_word(8'h36, 1'b1));
    run_word(w, iq);
    chk(w == exp_word(8'h4C, 1'b1), "R6 write appears next word", w, exp_word(8'h4C, 1'b1));
  endtask

  task automatic t_irq_eow();
    logic [15:0] w, iq;
    en = 1'b1;
    run_word(w, iq);
    chk(iq == 16'h8000, "R7 pulse only after last slot", iq, 16'h8000);
  endtask

  task automatic t_irq_change();
    @(negedge clk) mode = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R8 pulse on switch to idle", irq, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R8 pulse lasts one cycle", irq, 0);
    mode = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R8 pulse on switch to message", irq, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R8 second pulse ends", irq, 0);
  endtask

  task automatic t_irq_off();
    logic [15:0] w, iq;
    logic seen;
    en = 1'b0;
    @(negedge clk) msg = 8'hFF;
    @(negedge clk);
    seen = irq;
    run_word(w, iq);
    chk(!seen && iq == 16'h0000, "R9 disabled interrupt stays low", {15'd0, seen} | iq, 0);
    msg = 8'h36;
    run_word(w, iq);
  endtask

  task automatic t_coincide();
    logic [15:0] w, iq;
    logic b, q1;
    en = 1'b1;
    run_word(w, iq);
    for (int i = 0; i < 15; i++) step_slot(w[i], iq[i]);
    @(negedge clk) begin stb = 1'b1; msg = 8'hFF; end
    @(negedge clk) stb = 1'b0;
    b = fb; q1 = irq;
    chk(b == 1'b0, "R10 slot 15 keeps old byte bit7", b, 0);
    chk(q1 == 1'b1, "R10 coincident pulse raised", q1, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R10 single pulse", irq, 0);
    run_word(w, iq);
    chk(w == 16'hFFFF, "R10 new status governs next word", w, 16'hFFFF);
  endtask

  initial begin
    t_reset();
    t_valid();
    t_invalid();
    t_mode();
    t_midword();
    t_irq_eow();
    t_irq_change();
    t_irq_off();
    t_coincide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule